// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Engine

This block is the device-side control logic of a byte-wide electrically erasable memory. The host reaches it through SRAM-like asynchronous strobes (chip select, output enable and write enable, all active low), which the block samples on its own system clock. Each write strobe loads one byte into a page buffer that holds a whole page. A per-byte valid mask records which bytes were loaded. The host may load the bytes in any order and may rewrite a byte before the load ends.

The load closes when no write strobe has been seen for a set number of cycles. A timed programming cycle then begins. At its end, only the bytes marked in the mask are copied into the storage array. The rest of the page keeps its old contents. While programming runs, a read does not return array data. It returns a status byte instead. Bit 7 of that byte is the inverse of bit 7 of the last byte loaded, and bit 6 flips after each completed read. The load-window and programming durations are parameters counted in clock cycles. The defaults match 150 µs and 10 ms at 250 MHz. The page count is a parameter, and the default keeps the array model small.

Top module: `eep_page_engine`

## Requirements
- R1: `rdata_oe` is 1 exactly when `chip_sel_n`=0, `out_en_n`=0 and `wr_en_n`=1. When `rdata_oe` is 0, `rdata_o` reads as 0.
- R2: A write strobe exists only while `chip_sel_n`=0, `wr_en_n`=0 and `out_en_n`=1. With `out_en_n` low, holding the select and write enables low loads nothing and starts no programming.
- R3: The byte address is taken from `addr_i` in the first cycle of a strobe. The data is the value on `wdata_i` in the last cycle in which the strobe is active.
- R4: The page number is `addr_i[ADDR_W-1:NB_W]` and the byte offset is `addr_i[NB_W-1:0]`. The first strobe of a load fixes the page. A later strobe in the same load that names another page is ignored and changes no buffered byte.
- R5: Bytes may be loaded in any order. If one offset is written more than once in a load, the last value is the one programmed.
- R6: At the end of programming, only the offsets loaded in that load are updated. Every other byte of the page keeps its previous value.
- R7: Each strobe restarts the load window. Once `LOAD_CYC` cycles pass with no strobe, programming begins. A strobe that arrives inside the window joins the same load.
- R8: Programming lasts `PROG_CYC` cycles, after which the array holds the new data. Write strobes issued during programming are ignored.
- R9: During programming, bit 7 of a read returns the inverse of bit 7 of the last byte accepted in that load. After programming, reads return the true stored data.
- R10: During programming, bit 6 of a read is 0 on the first read after a load starts, and it inverts after each completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| addr_i | input | ADDR_W | Page number in the upper bits, byte offset in the low NB_W bits |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, or the status byte while programming |
| rdata_oe | output | 1 | High when the data outputs should be driven |

## Verification
A wrong mask or buffer state stays hidden until programming ends. It then appears as a changed neighbour byte, a missing byte or a stale byte when the whole page is read back, roughly `LOAD_CYC`+`PROG_CYC` cycles after the last strobe. A wrong load-window or programming-phase state shows much sooner. Reads that should return stored data return the status byte (or the reverse), or bytes from a strobe that should have been ignored turn up in the array. A wrong toggle or last-byte register shows on bit 6 or bit 7 within the first two polling reads.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eep_state_e;
endpackage

// File: rtl/eep_strobe.sv
module eep_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_act,
    output logic wr_start,
    output logic wr_end,
    output logic rd_act,
    output logic rd_end
);
    typedef struct packed {
        logic wr;
        logic rd;
    } strb_t;

    strb_t s_d, s_q;

    always_comb begin
        wr_act   = !cs_n && !we_n && oe_n;
        rd_act   = !cs_n && !oe_n && we_n;
        s_d.wr   = wr_act;
        s_d.rd   = rd_act;
        wr_start = wr_act && !s_q.wr;
        wr_end   = !wr_act && s_q.wr;
        rd_end   = !rd_act && s_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: a write strobe and a read access never coexist
    p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.wr && s_q.rd));
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int NB_W = 7,
    parameter int DW   = 8,
    localparam int NB  = 1 << NB_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wen,
    input  logic [NB_W-1:0]        woff,
    input  logic [DW-1:0]          wdata,
    output logic [NB-1:0][DW-1:0]  data_o,
    output logic [NB-1:0]          mask_o
);
    logic [NB-1:0][DW-1:0] buf_d, buf_q;
    logic [NB-1:0]         mask_d, mask_q;

    always_comb begin
        buf_d  = buf_q;
        mask_d = clr ? '0 : mask_q;
        if (wen) begin
            buf_d[woff]  = wdata;
            mask_d[woff] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            mask_q <= '0;
        end else begin
            buf_q  <= buf_d;
            mask_q <= mask_d;
        end
    end

    assign data_o = buf_q;
    assign mask_o = mask_q;

    // R6: loaded bits are never dropped within a load
    p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int NB_W = 7,
    parameter int PG_W = 4,
    parameter int DW   = 8,
    localparam int NB  = 1 << NB_W,
    localparam int AW  = NB_W + PG_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic                  clk,
    input  logic                  commit,
    input  logic [PG_W-1:0]       page,
    input  logic [NB-1:0]         mask,
    input  logic [NB-1:0][DW-1:0] pdata,
    input  logic [AW-1:0]         raddr,
    output logic [DW-1:0]         rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < NB; i++) begin
                if (mask[i]) mem[{page, NB_W'(i)}] <= pdata[i];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eep_page_engine.sv
module eep_page_engine
    import eep_pkg::*;
#(
    parameter int NB_W     = 7,
    parameter int PG_W     = 4,
    parameter int DW       = 8,
    parameter int LOAD_CYC = 37500,
    parameter int PROG_CYC = 2500000,
    localparam int ADDR_W  = NB_W + PG_W,
    localparam int NB      = 1 << NB_W,
    localparam int MAXC    = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC,
    localparam int CNT_W   = $clog2(MAXC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              rdata_oe
);
    typedef struct packed {
        eep_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [PG_W-1:0]  page;
        logic [NB_W-1:0]  off;
        logic             acc;
        logic [DW-1:0]    hold;
        logic [DW-1:0]    last;
        logic             tog;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic wr_act, wr_start, wr_end, rd_act, rd_end;
    logic buf_clr, buf_we, commit;
    logic [NB-1:0][DW-1:0] buf_data;
    logic [NB-1:0]         buf_mask;
    logic [DW-1:0]         arr_rdata;
    logic [PG_W-1:0]       addr_page;

    assign addr_page = addr_i[ADDR_W-1:NB_W];

    eep_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (chip_sel_n),
        .oe_n     (out_en_n),
        .we_n     (wr_en_n),
        .wr_act   (wr_act),
        .wr_start (wr_start),
        .wr_end   (wr_end),
        .rd_act   (rd_act),
        .rd_end   (rd_end)
    );

    eep_page_buf #(.NB_W(NB_W), .DW(DW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (buf_clr),
        .wen    (buf_we),
        .woff   (ctl_q.off),
        .wdata  (ctl_q.hold),
        .data_o (buf_data),
        .mask_o (buf_mask)
    );

    eep_array #(.NB_W(NB_W), .PG_W(PG_W), .DW(DW)) u_arr (
        .clk    (clk),
        .commit (commit),
        .page   (ctl_q.page),
        .mask   (buf_mask),
        .pdata  (buf_data),
        .raddr  (addr_i),
        .rdata  (arr_rdata)
    );

    always_comb begin
        ctl_d   = ctl_q;
        buf_clr = 1'b0;
        buf_we  = 1'b0;
        commit  = 1'b0;
        if (wr_act) ctl_d.hold = wdata_i;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (wr_start) begin
                    ctl_d.state = ST_LOAD;
                    ctl_d.page  = addr_page;
                    ctl_d.off   = addr_i[NB_W-1:0];
                    ctl_d.acc   = 1'b1;
                    ctl_d.cnt   = '0;
                    ctl_d.tog   = 1'b0;
                    buf_clr     = 1'b1;
                end
            end
            ST_LOAD: begin
                if (wr_start) begin
                    ctl_d.off = addr_i[NB_W-1:0];
                    ctl_d.acc = (addr_page == ctl_q.page);
                end
                if (wr_end && ctl_q.acc) begin
                    buf_we     = 1'b1;
                    ctl_d.last = ctl_q.hold;
                end
                if (wr_act || wr_end) begin
                    ctl_d.cnt = '0;
                end else if (ctl_q.cnt == CNT_W'(LOAD_CYC - 1)) begin
                    ctl_d.state = ST_PROG;
                    ctl_d.cnt   = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_PROG: begin
                if (wr_start) ctl_d.acc = 1'b0;
                if (rd_end)   ctl_d.tog = !ctl_q.tog;
                if (ctl_q.cnt == CNT_W'(PROG_CYC - 1)) begin
                    commit      = 1'b1;
                    ctl_d.state = ST_IDLE;
                    ctl_d.cnt   = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rdata_oe = rd_act;
        if (!rd_act)                    rdata_o = '0;
        else if (ctl_q.state == ST_PROG) rdata_o = {!ctl_q.last[DW-1], ctl_q.tog, ctl_q.last[DW-3:0]};
        else                            rdata_o = arr_rdata;
    end

    // R4: page of a load stays fixed while loading
    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_LOAD) |=> (ctl_q.state != ST_LOAD) || $stable(ctl_q.page));
    // R7: an idle window of LOAD_CYC cycles moves to programming
    p_load_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_LOAD && ctl_q.cnt == CNT_W'(LOAD_CYC - 1) && !wr_act && !wr_end)
        |=> (ctl_q.state == ST_PROG));
    // R8: programming is not cut short
    p_prog_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_PROG && ctl_q.cnt != CNT_W'(PROG_CYC - 1)) |=> (ctl_q.state == ST_PROG));
    // R8: no byte enters the buffer during programming
    p_prog_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_PROG) |=> $stable(buf_mask));
    // R10: toggle starts from 0 on every new load
    p_tog_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE && wr_start) |=> !ctl_q.tog);
endmodule

// File: tb/test_eep_page_engine.sv
module test_eep_page_engine;
    localparam int NB_W = 7;
    localparam int PG_W = 4;
    localparam int DW = 8;
    localparam int LOAD_CYC = 24;
    localparam int PROG_CYC = 160;
    localparam int NB = 1 << NB_W;
    localparam int AW = NB_W + PG_W;

    logic clk = 0;
    logic rst_n = 0;
    logic cs_n = 1, oe_n = 1, we_n = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdata_oe;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    logic [DW-1:0] ref_mem [1 << AW];
    logic [DW-1:0] pend [NB];
    logic          pmask [NB];
    logic [PG_W-1:0] cur_pg;

    always #2 clk = ~clk;

    eep_page_engine #(.NB_W(NB_W), .PG_W(PG_W), .DW(DW),
                      .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) i_eep_page_engine (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(cs_n), .out_en_n(oe_n), .wr_en_n(we_n),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe(rdata_oe));

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input logic [PG_W-1:0] pg, input logic [NB_W-1:0] off);
        return {pg, off};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 0; we_n = 0; oe_n = 1;
        idle(2);
        we_n = 1; cs_n = 1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
        @(negedge clk);
        addr = a; cs_n = 0; oe_n = 0; we_n = 1;
        idle(2);
        d = rdata; en = rdata_oe;
        oe_n = 1; cs_n = 1;
        @(negedge clk);
    endtask

    // model: start a load on page pg
    task automatic mstart(input logic [PG_W-1:0] pg);
        cur_pg = pg;
        for (int i = 0; i < NB; i++) pmask[i] = 0;
    endtask

    task automatic mwr(input logic [NB_W-1:0] off, input logic [DW-1:0] d);
        wr(mk(cur_pg, off), d);
        pend[off] = d; pmask[off] = 1;
    endtask

    task automatic mfinish();
        idle(LOAD_CYC + PROG_CYC + 8);
        for (int i = 0; i < NB; i++) if (pmask[i]) ref_mem[mk(cur_pg, NB_W'(i))] = pend[i];
    endtask

    task automatic verify_page(input logic [PG_W-1:0] pg, input string tag);
        logic [DW-1:0] d; logic en;
        for (int i = 0; i < NB; i++) begin
            rd(mk(pg, NB_W'(i)), d, en);
            chk(tag, d, ref_mem[mk(pg, NB_W'(i))]);
        end
    endtask

    initial begin : watchdog
        while (!done && cyc < 150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] d; logic en; logic [DW-1:0] d2; logic en2;
        void'($urandom(32'd2024));
        idle(3);
        chk("R1 reset oe", rdata_oe, 0);
        chk("R1 reset data", rdata, 0);
        rst_n = 1;
        idle(2);

        // prefill pages 0..3 fully
        for (int p = 0; p < 4; p++) begin
            mstart(PG_W'(p));
            for (int i = 0; i < NB; i++) mwr(NB_W'(i), DW'($urandom));
            mfinish();
        end
        verify_page(0, "R6 prefill page0");

        // R1 output gating
        @(negedge clk); addr = mk(1, 5); cs_n = 0; oe_n = 0; we_n = 1;
        idle(1); chk("R1 read drives", rdata_oe, 1); chk("R1 read data", rdata, ref_mem[mk(1, 5)]);
        cs_n = 1; idle(1); chk("R1 cs high", rdata_oe, 0); chk("R1 cs high data", rdata, 0);
        cs_n = 0; oe_n = 1; idle(1); chk("R1 oe high", rdata_oe, 0);
        oe_n = 1; cs_n = 1; idle(1);

        // R2: oe low blocks write
        @(negedge clk); addr = mk(1, 9); wdata = ~ref_mem[mk(1, 9)]; cs_n = 0; we_n = 0; oe_n = 0;
        idle(3); chk("R1 we low no drive", rdata_oe, 0);
        cs_n = 1; we_n = 1; oe_n = 1;
        idle(LOAD_CYC + 4);
        rd(mk(1, 9), d, en);
        chk("R2 no programming", d, ref_mem[mk(1, 9)]);
        idle(PROG_CYC + 4);
        rd(mk(1, 9), d, en);
        chk("R2 not written", d, ref_mem[mk(1, 9)]);

        // R3: address at start, data at end
        mstart(2);
        @(negedge clk); addr = mk(2, 10); wdata = 8'h11; cs_n = 0; we_n = 0; oe_n = 1;
        idle(1); addr = mk(2, 11); wdata = 8'hA7;
        idle(1); we_n = 1; cs_n = 1; @(negedge clk);
        pend[10] = 8'hA7; pmask[10] = 1;
        // R9/R10 polling during programming
        idle(LOAD_CYC + 4);
        rd(mk(2, 10), d, en); chk("R9 poll bit7", d[7], 0); chk("R10 first read bit6", d[6], 0);
        rd(mk(2, 10), d2, en2); chk("R10 second read bit6", d2[6], 1);
        rd(mk(2, 10), d2, en2); chk("R10 third read bit6", d2[6], 0); chk("R9 poll bit7 again", d2[7], 0);
        mfinish();
        rd(mk(2, 10), d, en); chk("R3 data at end, addr at start", d, 8'hA7);
        rd(mk(2, 11), d, en); chk("R3 second addr untouched", d, ref_mem[mk(2, 11)]);
        chk("R9 true data after", d, ref_mem[mk(2, 11)]);

        // R4: foreign page strobe ignored
        mstart(3);
        mwr(20, 8'h35);
        wr(mk(1, 20), 8'hFF);
        idle(LOAD_CYC + 4);
        rd(mk(3, 20), d, en); chk("R9 bit7 from accepted byte", d[7], 1);
        mfinish();
        rd(mk(1, 20), d, en); chk("R4 other page unchanged", d, ref_mem[mk(1, 20)]);
        rd(mk(3, 20), d, en); chk("R4 own byte written", d, 8'h35);

        // R5: overwrite, any order
        mstart(0);
        mwr(100, 8'h01); mwr(3, 8'h02); mwr(100, 8'h5C);
        mfinish();
        rd(mk(0, 100), d, en); chk("R5 last value wins", d, 8'h5C);
        verify_page(0, "R6 partial page0");

        // R7: strobe inside window joins load
        mstart(1);
        mwr(40, 8'h66);
        idle(LOAD_CYC - 6);
        mwr(41, 8'h77);
        mfinish();
        rd(mk(1, 41), d, en); chk("R7 late byte joined", d, 8'h77);
        rd(mk(1, 40), d, en); chk("R7 early byte", d, 8'h66);

        // R8: writes during programming ignored
        mstart(2);
        mwr(60, 8'h12);
        idle(LOAD_CYC + 4);
        wr(mk(2, 61), ~ref_mem[mk(2, 61)]);
        mfinish();
        rd(mk(2, 61), d, en); chk("R8 write in prog ignored", d, ref_mem[mk(2, 61)]);
        rd(mk(2, 60), d, en); chk("R8 committed after prog", d, 8'h12);

        // random loads
        for (int k = 0; k < 6; k++) begin
            logic [PG_W-1:0] pg;
            int cnt;
            pg = PG_W'($urandom_range(0, 3));
            cnt = $urandom_range(1, 24);
            mstart(pg);
            for (int j = 0; j < cnt; j++) mwr(NB_W'($urandom), DW'($urandom));
            mfinish();
            verify_page(pg, "R6 random load");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule